// File: doc/BRIEF.md
# Bus Map Register File

This block holds the table of relocation entries used when devices on a narrow 18-bit I/O bus perform DMA into a 22-bit physical address space. Each entry is a 22-bit physical base. A host processor reaches an entry through two 16-bit registers. The lower-addressed register of the pair carries entry bits 15:0. The upper register carries entry bits 21:16. The host may write a full 16-bit word or a single byte. The least significant bit of every entry is held at zero, so each base is always word aligned.

A separate translation datapath reads the entries combinationally through a lookup port. When the mapping hardware is not fitted (`map_present` low), every host access is answered with a nonexistent-register error and the table is not touched. Each host request gets a one-cycle registered response.

Top module: `bus_map_regfile`

## Requirements
- R1: After a synchronous active-low reset, every entry is zero, so every register reads 0 and the lookup port returns 0.
- R2: A word write with address bit 1 = 0 replaces entry bits 15:0 with the write data, with bit 0 forced to 0. Entry bits 21:16 are unchanged.
- R3: A word write with address bit 1 = 1 replaces entry bits 21:16 with write data bits 5:0. Write data bits 15:6 are discarded, and entry bits 15:0 are unchanged.
- R4: A byte write replaces the 8-bit lane starting at entry bit 8*addr[1:0] with write data bits 7:0, and leaves the other bits unchanged. Lane 0 keeps bit 0 at 0. Lane 2 keeps only its low 6 bits. Lane 3 changes nothing.
- R5: Entry bit 0 is always 0, as seen on a read of the low register and on the lookup port.
- R6: A read with address bit 1 = 0 returns entry bits 15:0. A read with address bit 1 = 1 returns entry bits 21:16 in bits 5:0, with bits 15:6 reading 0.
- R7: While `map_present` is low, every request is answered with `rsp_nxm` = 1 and `rsp_rdata` = 0, and no entry changes.
- R8: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `rsp_nxm` is never high without `rsp_valid`. A write response returns `rsp_rdata` = 0.
- R9: `lkup_entry` shows the entry selected by `lkup_idx` with no register delay. It reflects a write from the cycle after the write request.
- R10: The entry index is `req_addr[6:2]` (byte address, 4 bytes per entry pair). A write changes only the addressed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_present | input | 1 | High when the mapping hardware is configured present |
| req_valid | input | 1 | Host request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte write, 0 = word write |
| req_addr | input | 7 | Register byte address within the map window |
| req_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 16 | Read data (0 for writes and errors) |
| rsp_nxm | output | 1 | Nonexistent-register error |
| lkup_idx | input | 5 | Entry index for the translation datapath |
| lkup_entry | output | 22 | Selected entry for the translation datapath |

## Verification
A corrupted entry shows up on the lookup port in the cycle right after the write that caused it. It shows up on the host side in the response to the next read of that register pair. So the bench compares both paths against an arithmetic model after every access. A wrong index decode or a stray write enable leaves a neighbouring entry altered. To catch this, the bench rereads the whole table after each sweep. A missing guard on `map_present` is caught one cycle later. It appears either as a missing error flag or as an entry that differs once the hardware is enabled again.

// File: rtl/bmr_pkg.sv
// Package: shared widths, masks and the decoded-request type for the
// bus map register file. Assumes 16-bit host registers, 22-bit entries.
package bmr_pkg;
    localparam int ENTRY_W = 22;
    localparam int HALF_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int HI_W    = ENTRY_W - HALF_W;
    localparam logic [31:0] ENTRY_KEEP = 32'h003F_FFFE;

    typedef struct packed {
        logic       wr_en;
        logic       byte_mode;
        logic [1:0] lane;
        logic       hi_half;
    } bmr_ctl_t;
endpackage

// File: rtl/bmr_decode.sv
// Module: bmr_decode
// Splits a host register address into entry index, half and byte lane,
// and produces a one-hot write strobe gated by map presence.
// Assumes NUM_ENTRIES is a power of two so the index needs no range check.
module bmr_decode
    import bmr_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    localparam int IDX_W  = $clog2(NUM_ENTRIES),
    localparam int ADDR_W = IDX_W + 2
) (
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic                   req_byte,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic                   map_present,
    output logic [IDX_W-1:0]       idx,
    output bmr_ctl_t               ctl,
    output logic [NUM_ENTRIES-1:0] wr_sel
);
    // Field extraction from the register address.
    always_comb begin
        idx           = req_addr[ADDR_W-1:2];
        ctl.lane      = req_addr[1:0];
        ctl.hi_half   = req_addr[1];
        ctl.byte_mode = req_byte;
        ctl.wr_en     = req_valid & req_write & map_present;
    end

    // One-hot strobe per entry.
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_sel
        assign wr_sel[e] = ctl.wr_en && (idx == IDX_W'(e));
    end
endmodule

// File: rtl/bmr_merge.sv
// Module: bmr_merge
// Builds the next value of one entry from its old value and a word or
// byte write. Lanes above bit 21 fall away and bit 0 is cleared.
module bmr_merge
    import bmr_pkg::*;
(
    input  logic [ENTRY_W-1:0] old_entry,
    input  bmr_ctl_t           ctl,
    input  logic [HALF_W-1:0]  wdata,
    output logic [ENTRY_W-1:0] new_entry
);
    logic [4:0]  shamt;
    logic [31:0] image, put, keep, merged;

    // Shift amount: lane times 8 for bytes, half times 16 for words.
    always_comb begin
        if (ctl.byte_mode) shamt = {ctl.lane, 3'b000};
        else               shamt = {ctl.hi_half, 4'b0000};
    end

    // Lane merge followed by the fixed entry mask.
    always_comb begin
        image = {{(32-ENTRY_W){1'b0}}, old_entry};
        if (ctl.byte_mode) begin
            put  = {24'h0, wdata[BYTE_W-1:0]} << shamt;
            keep = ~(32'h0000_00FF << shamt);
        end else begin
            put  = {16'h0, wdata} << shamt;
            keep = ~(32'h0000_FFFF << shamt);
        end
        merged    = ((image & keep) | put) & ENTRY_KEEP;
        new_entry = merged[ENTRY_W-1:0];
    end
endmodule

// File: rtl/bmr_store.sv
// Module: bmr_store
// Entry storage: one register per entry, loaded from the shared merge
// result when its strobe is set. Synchronous active-low reset to zero.
module bmr_store
    import bmr_pkg::*;
#(
    parameter int NUM_ENTRIES = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_ENTRIES-1:0]              wr_sel,
    input  logic [ENTRY_W-1:0]                  wr_value,
    output logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] entries
);
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        // Hold or load one entry.
        always_ff @(posedge clk) begin
            if (!rst_n)         entries[e] <= '0;
            else if (wr_sel[e]) entries[e] <= wr_value;
        end
    end
endmodule

// File: rtl/bmr_readfmt.sv
// Module: bmr_readfmt
// Formats an entry for a host read of one of its two registers.
// The upper register returns only the top 6 bits, zero-extended.
module bmr_readfmt
    import bmr_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  logic               hi_half,
    output logic [HALF_W-1:0]  rdata
);
    // Half select with zero fill.
    always_comb begin
        if (hi_half) rdata = {{(HALF_W-HI_W){1'b0}}, entry[ENTRY_W-1:HALF_W]};
        else         rdata = {entry[HALF_W-1:1], 1'b0};
    end
endmodule

// File: rtl/bus_map_regfile.sv
// Module: bus_map_regfile
// Host-visible register file of DMA relocation entries. Host accesses
// receive a registered response one cycle later. A lookup port gives the
// translation datapath combinational access to any entry.
// Assumes one host request per cycle at most and NUM_ENTRIES a power of two.
module bus_map_regfile
    import bmr_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    localparam int IDX_W  = $clog2(NUM_ENTRIES),
    localparam int ADDR_W = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               map_present,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_byte,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [15:0]        req_wdata,
    output logic               rsp_valid,
    output logic [15:0]        rsp_rdata,
    output logic               rsp_nxm,
    input  logic [IDX_W-1:0]   lkup_idx,
    output logic [21:0]        lkup_entry
);
    logic [IDX_W-1:0]                  idx;
    bmr_ctl_t                          ctl;
    logic [NUM_ENTRIES-1:0]            wr_sel;
    logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] entries;
    logic [ENTRY_W-1:0]                cur_entry, next_entry;
    logic [HALF_W-1:0]                 fmt_data;

    bmr_decode #(.NUM_ENTRIES(NUM_ENTRIES)) u_dec (
        .req_valid(req_valid), .req_write(req_write), .req_byte(req_byte),
        .req_addr(req_addr), .map_present(map_present),
        .idx(idx), .ctl(ctl), .wr_sel(wr_sel)
    );

    // Entry addressed by the host request.
    assign cur_entry = entries[idx];

    bmr_merge u_merge (
        .old_entry(cur_entry), .ctl(ctl), .wdata(req_wdata),
        .new_entry(next_entry)
    );

    bmr_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel),
        .wr_value(next_entry), .entries(entries)
    );

    bmr_readfmt u_fmt (
        .entry(cur_entry), .hi_half(ctl.hi_half), .rdata(fmt_data)
    );

    // Translation-side lookup.
    assign lkup_entry = entries[lkup_idx];

    // Registered host response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_nxm   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_nxm   <= req_valid & ~map_present;
            rsp_rdata <= (req_valid && map_present && !req_write) ? fmt_data : '0;
        end
    end
endmodule

// File: rtl/bmr_checker.sv
// Module: bmr_checker
// Port-level temporal checks on bus_map_regfile, bound to every instance.
module bmr_checker #(
    parameter int NUM_ENTRIES = 32,
    localparam int IDX_W  = $clog2(NUM_ENTRIES),
    localparam int ADDR_W = IDX_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              map_present,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [15:0]       rsp_rdata,
    input logic              rsp_nxm,
    input logic [IDX_W-1:0]  lkup_idx,
    input logic [21:0]       lkup_entry
);
    a_r8_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r8_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r8_nxm_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_nxm |-> rsp_valid);
    a_r8_write_rsp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == 16'h0));
    a_r7_nxm_when_absent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !map_present) |=> (rsp_nxm && rsp_rdata == 16'h0));
    a_r7_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !map_present ##1 $stable(lkup_idx) |-> $stable(lkup_entry));
    a_r6_hi_reg_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[1]) |=> (rsp_rdata[15:6] == 10'h0));
    a_r5_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        lkup_entry[0] == 1'b0);
endmodule

bind bus_map_regfile bmr_checker #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .map_present(map_present),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_nxm(rsp_nxm),
    .lkup_idx(lkup_idx), .lkup_entry(lkup_entry)
);

// File: tb/sim_bus_map_regfile.sv
// Bench: sweeps every register with word and byte writes against an
// arithmetic model of the table, checks reads and the lookup port.
module sim_bus_map_regfile;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_present = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid, rsp_nxm;
    logic [15:0] rsp_rdata;
    logic [4:0]  lkup_idx = '0;
    logic [21:0] lkup_entry;

    logic [21:0] model [N];
    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bus_map_regfile u0 (
        .clk(clk), .rst_n(rst_n), .map_present(map_present),
        .req_valid(req_valid), .req_write(req_write), .req_byte(req_byte),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_nxm(rsp_nxm),
        .lkup_idx(lkup_idx), .lkup_entry(lkup_entry)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of a write, computed from the lane rules.
    function automatic logic [21:0] model_wr(input logic [21:0] e, input bit b,
                                             input logic [1:0] a, input logic [15:0] d);
        logic [31:0] img = {10'h0, e};
        int sh;
        if (b) begin
            sh = a * 8;
            img = (img & ~(32'hFF << sh)) | ({24'h0, d[7:0]} << sh);
        end else begin
            sh = a[1] * 16;
            img = (img & ~(32'hFFFF << sh)) | ({16'h0, d} << sh);
        end
        img = img & 32'h003F_FFFE;
        return img[21:0];
    endfunction

    function automatic logic [15:0] model_rd(input logic [21:0] e, input logic hi);
        return hi ? {10'h0, e[21:16]} : e[15:0];
    endfunction

    // One access; response sampled one negedge later.
    task automatic access(input bit w, input bit b, input logic [6:0] a,
                          input logic [15:0] d, output logic [15:0] rd,
                          output logic nxm, output logic vld);
        @(negedge clk);
        req_valid = 1; req_write = w; req_byte = b; req_addr = a; req_wdata = d;
        @(negedge clk);
        rd = rsp_rdata; nxm = rsp_nxm; vld = rsp_valid;
        req_valid = 0; req_write = 0; req_byte = 0;
    endtask

    task automatic write_chk(input string req, input bit b, input logic [6:0] a,
                             input logic [15:0] d);
        logic [15:0] rd; logic nxm, vld;
        access(1, b, a, d, rd, nxm, vld);
        model[a[6:2]] = model_wr(model[a[6:2]], b, a[1:0], d);
        lkup_idx = a[6:2];
        #1;
        check({req, " R9 lookup after write"}, {10'h0, lkup_entry}, {10'h0, model[a[6:2]]});
    endtask

    task automatic sweep_read(input string req);
        logic [15:0] rd; logic nxm, vld;
        for (int i = 0; i < 2*N; i++) begin
            access(0, 0, 7'(i*2), 16'h0, rd, nxm, vld);
            check({req, " R6 R10 read"}, {15'h0, nxm, rd}, {16'h0, model_rd(model[i/2], i[0])});
        end
    endtask

    initial begin
        logic [15:0] rd; logic nxm, vld;
        for (int i = 0; i < N; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R8 idle rsp_valid", {31'h0, rsp_valid}, 32'h0);
        for (int i = 0; i < N; i++) begin
            lkup_idx = 5'(i); #1;
            check("R1 reset lookup", {10'h0, lkup_entry}, 32'h0);
        end
        sweep_read("R1 reset");

        // Word writes, both halves, all entries (R2, R3, R5).
        for (int i = 0; i < N; i++) begin
            write_chk("R2 word lo", 0, 7'(i*4), 16'(i*16'h9E37 + 16'h1235));
            write_chk("R3 word hi", 0, 7'(i*4 + 2), 16'(i*16'h3B1D ^ 16'hFFC0));
        end
        sweep_read("R2 R3");

        // Odd-address word write acts on the same half (R2).
        write_chk("R2 odd addr word", 0, 7'd5, 16'hFFFF);
        check("R5 bit0 zero", {31'h0, lkup_entry[0]}, 32'h0);

        // Byte lanes across all entries (R4).
        for (int i = 0; i < N; i++)
            for (int l = 0; l < 4; l++)
                write_chk("R4 byte lane", 1, 7'(i*4 + l), 16'(16'hA5C3 + i*7 + l*64));
        sweep_read("R4");

        // Lane 3 and high write bits have no effect on that entry.
        write_chk("R4 lane3 no effect", 1, 7'd11, 16'h00FF);
        check("R4 lane3 entry", {10'h0, lkup_entry}, {10'h0, model[2]});

        // Writes to one entry leave neighbours alone (R10).
        write_chk("R10 isolate", 0, 7'd40, 16'h0000);
        sweep_read("R10");

        // R8: response strobe and write response data.
        access(1, 0, 7'd0, 16'h1234, rd, nxm, vld);
        model[0] = model_wr(model[0], 0, 2'd0, 16'h1234);
        check("R8 write rsp valid", {31'h0, vld}, 32'h1);
        check("R8 write rsp data", {16'h0, rd}, 32'h0);
        @(negedge clk);
        check("R8 valid drops", {31'h0, rsp_valid}, 32'h0);

        // Map absent: errors and no change (R7).
        map_present = 0;
        for (int i = 0; i < 2*N; i++) begin
            access(1, i[0], 7'(i*2), 16'hFFFF, rd, nxm, vld);
            check("R7 write nxm", {15'h0, nxm, rd}, 32'h0001_0000);
            access(0, 0, 7'(i*2), 16'h0, rd, nxm, vld);
            check("R7 read nxm", {15'h0, nxm, rd}, 32'h0001_0000);
        end
        map_present = 1;
        sweep_read("R7 unchanged");
        for (int i = 0; i < N; i++) begin
            lkup_idx = 5'(i); #1;
            check("R7 R9 lookup unchanged", {10'h0, lkup_entry}, {10'h0, model[i]});
        end

        // Reset clears a populated table (R1).
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < N; i++) model[i] = '0;
        sweep_read("R1 re-reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule